// File: doc/BRIEF.md
# Randomised Active-Vector PWM Sequencer

This block drives the three gate signals of a two-level three-phase inverter with a 3-bit switching state. It never emits the two zero states 000 and 111. A controller computes the interval counts elsewhere and hands them over: the duration of the first active state, the duration of the second active state, and a fill duration that takes the place of the zero-vector time. The fill duration is normally half of (half carrier period minus the two active durations). The controller also supplies the two active state codes of the current sector. Each half carrier period splits into four slots: fill, first active, second active, fill. In a trailing half the two active slots swap places, so the trailing half mirrors the leading half. A down-counter times every slot.

A pseudo-random bit is drawn for every half carrier period. It selects which active state fills the two fill slots. The number of gate commutations per carrier period therefore changes from one period to the next, and the harmonic energy spreads across the spectrum. The block reads new counts and codes only once per block of N half periods and raises a one-cycle request when that happens. The controller therefore has to recompute only once every N half periods.

Top module: `rcm_svm_seq`

## Requirements
- R1: While running, `phase_state` is never 000 or 111. Bit 2 is phase A, bit 1 is phase B and bit 0 is phase C.
- R2: The first half period after the first accepted load is a leading half, and halves then alternate. A leading half drives slots in the order fill, A, B, fill. A trailing half drives fill, B, A, fill. Slot A lasts `a_cnt` cycles, slot B lasts `b_cnt` cycles and each fill slot lasts `fill_cnt` cycles.
- R3: When the half's random bit is 1, both fill slots drive the A code. A leading half and the trailing half after it, both with random bit 1, therefore give the order A, A, B, A, A, B, A, A.
- R4: When the half's random bit is 0, both fill slots drive the B code.
- R5: The random bit comes from a 16-bit shift register seeded with 0xACE1 at reset. At the start of each half period it shifts left and inserts bit15 XOR bit13 XOR bit12 XOR bit10 at bit 0. That inserted bit is the half period's random bit.
- R6: A block is N consecutive half periods. At the clock edge that starts a block, the counts and codes are captured and `sample_req` is high for the first cycle of that block. All halves of the block use the captured values, whatever the inputs do in the meantime.
- R7: `n_half` is captured only at a block boundary, and it sets the length of the block that starts there. A value of 0 is treated as 1.
- R8: From reset until the first accepted load, `phase_state` is 100 and `sample_req` is 0.
- R9: A slot whose count is 0 is skipped and takes no clock cycle.
- R10: A half period in which every slot count is 0 lasts exactly one cycle and drives the first fill slot's code.
- R11: A load is accepted only when `load_vld` is 1, `a_code` has exactly one bit set and `b_code` has exactly two bits set. If any of these fails, the block stays idle when idle, and keeps its previous values when running.
- R12: If no load is accepted at a block boundary, the previous counts and codes are reused and `sample_req` still pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_vld | input | 1 | Counts and codes on the inputs are valid |
| a_cnt | input | CNT_W | Duration of the first active state, in cycles |
| b_cnt | input | CNT_W | Duration of the second active state, in cycles |
| fill_cnt | input | CNT_W | Duration of each substitute (fill) slot, in cycles |
| a_code | input | 3 | First active state code (one bit set) |
| b_code | input | 3 | Second active state code (two bits set) |
| n_half | input | NH_W | Half periods per sampling block |
| sample_req | output | 1 | High for the first cycle of each block |
| phase_state | output | 3 | Gate state, bit 2 = phase A |

## Verification
Most internal faults show at the ports within one half period. A wrong slot or a slot counter that is off by one moves a code edge by a cycle, or drops a code from the order. A corrupt random register changes which code fills the fill slots. A faulty block counter shifts a `sample_req` pulse, or picks up new counts a half period early or late. The bench therefore holds a cycle-exact expected stream of codes and requests, and compares it with the outputs on every cycle. It changes the inputs on every cycle inside a block so that a premature capture shows up right away.

// File: rtl/rcm_pkg.sv
package rcm_pkg;

    // Role of a slot inside a half carrier period.
    typedef enum logic [1:0] {
        SLOT_FILL = 2'd0,
        SLOT_A    = 2'd1,
        SLOT_B    = 2'd2
    } slot_kind_e;

    localparam int unsigned SLOTS_PER_HALF = 4;
    localparam logic [2:0]  PARK_CODE      = 3'b100;

    // Leading half: fill, A, B, fill. Trailing half mirrors it: fill, B, A, fill.
    function automatic slot_kind_e kind_of(input logic trail, input logic [1:0] idx);
        slot_kind_e k;
        unique case (idx)
            2'd1:    k = trail ? SLOT_B : SLOT_A;
            2'd2:    k = trail ? SLOT_A : SLOT_B;
            default: k = SLOT_FILL;
        endcase
        return k;
    endfunction

    function automatic logic one_high(input logic [2:0] c);
        return (c == 3'b100) || (c == 3'b010) || (c == 3'b001);
    endfunction

    function automatic logic two_high(input logic [2:0] c);
        return (c == 3'b110) || (c == 3'b011) || (c == 3'b101);
    endfunction

endpackage

// File: rtl/rcm_lfsr.sv
module rcm_lfsr #(
    parameter int unsigned           WIDTH = 16,
    parameter logic [WIDTH-1:0]      TAPS  = 16'hB400,
    parameter logic [WIDTH-1:0]      SEED  = 16'hACE1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    output logic fb_bit
);

    logic [WIDTH-1:0] state_d, state_q;

    always_comb begin
        fb_bit  = ^(state_q & TAPS);
        state_d = step ? {state_q[WIDTH-2:0], fb_bit} : state_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEED;
        else        state_q <= state_d;
    end

    // The register must never lock up in the all-zero state.
    assert_lfsr_alive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0);

    // It only moves when a half period starts.
    assert_lfsr_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(state_q));

endmodule

// File: rtl/rcm_slot_pick.sv
module rcm_slot_pick
    import rcm_pkg::*;
#(
    parameter int unsigned CNT_W = 12
) (
    input  logic             trail,
    input  logic [2:0]       from_idx,
    input  logic [CNT_W-1:0] a_dur,
    input  logic [CNT_W-1:0] b_dur,
    input  logic [CNT_W-1:0] fill_dur,
    output logic             found,
    output logic [1:0]       slot,
    output logic [CNT_W-1:0] dur
);

    logic [SLOTS_PER_HALF-1:0][CNT_W-1:0] slot_dur;
    logic [SLOTS_PER_HALF-1:0]            live;

    for (genvar g = 0; g < SLOTS_PER_HALF; g++) begin : g_slot
        slot_kind_e k;
        assign k           = kind_of(trail, 2'(g));
        assign slot_dur[g] = (k == SLOT_A) ? a_dur :
                             (k == SLOT_B) ? b_dur : fill_dur;
        assign live[g]     = (slot_dur[g] != '0) && (3'(g) >= from_idx);
    end

    // Lowest-numbered live slot at or after from_idx wins.
    always_comb begin
        found = |live;
        slot  = '0;
        dur   = '0;
        for (int i = int'(SLOTS_PER_HALF) - 1; i >= 0; i--) begin
            if (live[i]) begin
                slot = 2'(i);
                dur  = slot_dur[i];
            end
        end
    end

endmodule

// File: rtl/rcm_pattern.sv
module rcm_pattern
    import rcm_pkg::*;
(
    input  logic       trail,
    input  logic       rb,
    input  logic [1:0] slot,
    input  logic [2:0] a_code,
    input  logic [2:0] b_code,
    output logic [2:0] code
);

    always_comb begin
        unique case (kind_of(trail, slot))
            SLOT_A:  code = a_code;
            SLOT_B:  code = b_code;
            default: code = rb ? a_code : b_code;
        endcase
    end

endmodule

// File: rtl/rcm_svm_seq.sv
module rcm_svm_seq
    import rcm_pkg::*;
#(
    parameter int unsigned         CNT_W     = 12,
    parameter int unsigned         NH_W      = 4,
    parameter int unsigned         LFSR_W    = 16,
    parameter logic [LFSR_W-1:0]   LFSR_TAPS = 16'hB400,
    parameter logic [LFSR_W-1:0]   LFSR_SEED = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_vld,
    input  logic [CNT_W-1:0] a_cnt,
    input  logic [CNT_W-1:0] b_cnt,
    input  logic [CNT_W-1:0] fill_cnt,
    input  logic [2:0]       a_code,
    input  logic [2:0]       b_code,
    input  logic [NH_W-1:0]  n_half,
    output logic             sample_req,
    output logic [2:0]       phase_state
);

    localparam logic [CNT_W-1:0] ONE_CNT = CNT_W'(1);
    localparam logic [NH_W-1:0]  ONE_NH  = NH_W'(1);

    typedef struct packed {
        logic             run;
        logic             trail;
        logic             rb;
        logic [1:0]       slot;
        logic [CNT_W-1:0] left;
        logic [NH_W-1:0]  hcnt;
        logic [NH_W-1:0]  nblk;
        logic [CNT_W-1:0] ta;
        logic [CNT_W-1:0] tb;
        logic [CNT_W-1:0] tf;
        logic [2:0]       sa;
        logic [2:0]       sb;
        logic             req;
    } seq_t;

    seq_t s_d, s_q;

    logic             load_ok, expire, new_half, at_block, take, next_trail, fb_bit;
    logic             rest_found, head_found;
    logic [1:0]       rest_slot, head_slot;
    logic [CNT_W-1:0] rest_dur, head_dur;
    logic [CNT_W-1:0] sel_ta, sel_tb, sel_tf;
    logic [2:0]       rest_from, live_code;
    logic [NH_W-1:0]  n_eff;

    // ---------------- event decode ----------------
    assign load_ok    = load_vld && one_high(a_code) && two_high(b_code);
    assign expire     = s_q.run && (s_q.left == ONE_CNT);
    assign rest_from  = {1'b0, s_q.slot} + 3'd1;
    assign new_half   = s_q.run ? (expire && !rest_found) : load_ok;
    assign at_block   = !s_q.run || (s_q.hcnt == s_q.nblk - ONE_NH);
    assign take       = new_half && at_block && load_ok;
    assign next_trail = s_q.run ? !s_q.trail : 1'b0;
    assign n_eff      = (n_half == '0) ? ONE_NH : n_half;
    assign sel_ta     = take ? a_cnt    : s_q.ta;
    assign sel_tb     = take ? b_cnt    : s_q.tb;
    assign sel_tf     = take ? fill_cnt : s_q.tf;

    // Next live slot later in the current half.
    rcm_slot_pick #(.CNT_W(CNT_W)) u_rest (
        .trail    (s_q.trail),
        .from_idx (rest_from),
        .a_dur    (s_q.ta),
        .b_dur    (s_q.tb),
        .fill_dur (s_q.tf),
        .found    (rest_found),
        .slot     (rest_slot),
        .dur      (rest_dur)
    );

    // First live slot of the half that starts next, with the counts it will use.
    rcm_slot_pick #(.CNT_W(CNT_W)) u_head (
        .trail    (next_trail),
        .from_idx (3'd0),
        .a_dur    (sel_ta),
        .b_dur    (sel_tb),
        .fill_dur (sel_tf),
        .found    (head_found),
        .slot     (head_slot),
        .dur      (head_dur)
    );

    rcm_lfsr #(
        .WIDTH (LFSR_W),
        .TAPS  (LFSR_TAPS),
        .SEED  (LFSR_SEED)
    ) u_lfsr (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (new_half),
        .fb_bit (fb_bit)
    );

    rcm_pattern u_pattern (
        .trail  (s_q.trail),
        .rb     (s_q.rb),
        .slot   (s_q.slot),
        .a_code (s_q.sa),
        .b_code (s_q.sb),
        .code   (live_code)
    );

    // ---------------- next state ----------------
    always_comb begin
        s_d     = s_q;
        s_d.req = 1'b0;
        if (new_half) begin
            s_d.run   = 1'b1;
            s_d.trail = next_trail;
            s_d.rb    = fb_bit;
            if (head_found) begin
                s_d.slot = head_slot;
                s_d.left = head_dur;
            end else begin
                s_d.slot = 2'd0;
                s_d.left = ONE_CNT;
            end
            if (at_block) begin
                s_d.hcnt = '0;
                s_d.nblk = n_eff;
                s_d.req  = 1'b1;
            end else begin
                s_d.hcnt = s_q.hcnt + ONE_NH;
            end
            if (take) begin
                s_d.ta = a_cnt;
                s_d.tb = b_cnt;
                s_d.tf = fill_cnt;
                s_d.sa = a_code;
                s_d.sb = b_code;
            end
        end else if (s_q.run) begin
            if (expire) begin
                s_d.slot = rest_slot;
                s_d.left = rest_dur;
            end else begin
                s_d.left = s_q.left - ONE_CNT;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.nblk <= ONE_NH;
            s_q.sa   <= PARK_CODE;
            s_q.sb   <= 3'b110;
        end else begin
            s_q <= s_d;
        end
    end

    assign sample_req  = s_q.req;
    assign phase_state = s_q.run ? live_code : PARK_CODE;

    // ---------------- assertions ----------------
    assert_no_zero_vector_R1: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.run |-> (phase_state != 3'b000) && (phase_state != 3'b111));

    assert_slot_live_R9: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.run |-> (s_q.left != '0));

    assert_req_at_block_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sample_req |-> (s_q.hcnt == '0) && s_q.run);

    assert_times_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.run && !sample_req) |-> $stable({s_q.ta, s_q.tb, s_q.tf, s_q.sa, s_q.sb}));

    assert_block_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.run |-> (s_q.hcnt < s_q.nblk) && (s_q.nblk != '0));

    assert_park_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.run |-> (phase_state == PARK_CODE) && !sample_req);

    assert_codes_legal_R11: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.run |-> one_high(s_q.sa) && two_high(s_q.sb));

endmodule

// File: tb/rcm_svm_seq_bench.sv
module rcm_svm_seq_bench;

    localparam int CW = 12;
    localparam int NW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load_vld = 1'b0;
    logic [CW-1:0] ta = '0, tb = '0, tf = '0;
    logic [2:0]    sa = 3'b100, sb = 3'b110;
    logic [NW-1:0] nh = 4'd1;
    logic          req;
    logic [2:0]    ps;

    always #10 clk = ~clk;

    rcm_svm_seq #(.CNT_W(CW), .NH_W(NW)) u_rcm_svm_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_vld    (load_vld),
        .a_cnt       (ta),
        .b_cnt       (tb),
        .fill_cnt    (tf),
        .a_code      (sa),
        .b_code      (sb),
        .n_half      (nh),
        .sample_req  (req),
        .phase_state (ps)
    );

    int n_checks = 0;
    int n_fail   = 0;

    // ---------- reference model built from the requirements ----------
    bit            m_run, m_trail, m_rb, m_req, m_lead_rb1, seen_all1, seen_rb0;
    logic [15:0]   m_lfsr;
    int            m_hcnt, m_n;
    logic [CW-1:0] m_ta, m_tb, m_tf;
    logic [2:0]    m_sa, m_sb;
    logic [2:0]    m_q[$];

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic bit ok_now();
        return load_vld && ($countones(sa) == 1) && ($countones(sb) == 2);
    endfunction

    function automatic logic [2:0] code_of(input int k);
        bit is_a, is_b;
        is_a = m_trail ? (k == 2) : (k == 1);
        is_b = m_trail ? (k == 1) : (k == 2);
        if (is_a) return m_sa;
        if (is_b) return m_sb;
        return m_rb ? m_sa : m_sb;
    endfunction

    function automatic int dur_of(input int k);
        if (k == 0 || k == 3) return int'(m_tf);
        if ((k == 1) != m_trail) return int'(m_ta);
        return int'(m_tb);
    endfunction

    task automatic build_half(input bit first);
        bit fbv, blk;
        blk     = first || (m_hcnt == m_n - 1);
        m_trail = first ? 1'b0 : ~m_trail;
        fbv     = m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10];
        m_lfsr  = {m_lfsr[14:0], fbv};
        m_rb    = fbv;
        if (blk) begin
            m_hcnt = 0;
            m_n    = (nh == 0) ? 1 : int'(nh);
            m_req  = 1'b1;
            if (ok_now()) begin
                m_ta = ta; m_tb = tb; m_tf = tf; m_sa = sa; m_sb = sb;
            end
        end else begin
            m_hcnt++;
        end
        for (int k = 0; k < 4; k++) begin
            for (int c = 0; c < dur_of(k); c++) m_q.push_back(code_of(k));
        end
        if (m_q.size() == 0) m_q.push_back(code_of(0));
        if (!m_trail) m_lead_rb1 = m_rb;
        else if (m_lead_rb1 && m_rb) seen_all1 = 1'b1;
        if (!m_rb) seen_rb0 = 1'b1;
    endtask

    task automatic step(input string tag);
        @(negedge clk);
        m_req = 1'b0;
        if (m_run) begin
            void'(m_q.pop_front());
            if (m_q.size() == 0) build_half(1'b0);
        end else if (ok_now()) begin
            m_run = 1'b1;
            build_half(1'b1);
        end
        check({tag, " state"}, 32'(ps), m_run ? 32'(m_q[0]) : 32'(3'b100));
        check({tag, " req"}, 32'(req), 32'(m_req));
        check("R1 zero vector", 32'((ps == 3'b000) || (ps == 3'b111)), 32'd0);
    endtask

    task automatic do_reset();
        rst_n    = 1'b0;
        load_vld = 1'b0;
        repeat (3) @(negedge clk);
        check("R8 state in reset", 32'(ps), 32'(3'b100));
        check("R8 req in reset", 32'(req), 32'd0);
        m_run = 0; m_trail = 0; m_rb = 0; m_lead_rb1 = 0;
        m_lfsr = 16'hACE1; m_hcnt = 0; m_n = 1;
        m_q.delete();
        rst_n = 1'b1;
    endtask

    // ---------- scenarios ----------
    task automatic test_reset();
        do_reset();
        ta = 3; tb = 2; tf = 1;
        repeat (6) step("R8 idle");
        check("R8 idle parked", 32'(ps), 32'(3'b100));
    endtask

    task automatic test_basic();
        do_reset();
        seen_all1 = 0; seen_rb0 = 0;
        ta = 3; tb = 2; tf = 1; sa = 3'b100; sb = 3'b110; nh = 1; load_vld = 1;
        repeat (250) step("R2 R5 basic");
        sa = 3'b001; sb = 3'b011; ta = 2; tb = 4; tf = 2;
        repeat (150) step("R2 R5 sector");
        check("R3 both halves rb=1 seen", 32'(seen_all1), 32'd1);
        check("R4 rb=0 fill seen", 32'(seen_rb0), 32'd1);
    endtask

    task automatic test_hold();
        do_reset();
        ta = 2; tb = 1; tf = 1; sa = 3'b010; sb = 3'b011; nh = 3; load_vld = 1;
        for (int i = 0; i < 300; i++) begin
            step("R6 hold");
            ta = CW'(1 + (i % 5));
            tb = CW'(i % 3);
            tf = CW'(1 + (i % 2));
            case (i % 3)
                0: begin sa = 3'b100; sb = 3'b101; end
                1: begin sa = 3'b010; sb = 3'b110; end
                default: begin sa = 3'b001; sb = 3'b011; end
            endcase
        end
    endtask

    task automatic test_nchange();
        do_reset();
        ta = 1; tb = 1; tf = 1; sa = 3'b100; sb = 3'b110; nh = 2; load_vld = 1;
        for (int i = 0; i < 240; i++) begin
            step("R7 n change");
            if (i % 23 == 0) nh = (nh == 4) ? 4'd0 : nh + 4'd1;
        end
    endtask

    task automatic test_zero();
        do_reset();
        ta = 2; tb = 0; tf = 0; sa = 3'b100; sb = 3'b101; nh = 1; load_vld = 1;
        repeat (60) step("R9 skip zero");
        ta = 0; tb = 0; tf = 0;
        repeat (40) step("R10 empty half");
        ta = 0; tb = 3; tf = 1;
        repeat (60) step("R9 skip A");
    endtask

    task automatic test_invalid();
        do_reset();
        ta = 2; tb = 2; tf = 1; nh = 1; load_vld = 1;
        sa = 3'b011; sb = 3'b110;
        repeat (8) step("R11 bad A code");
        check("R11 still parked", 32'(ps), 32'(3'b100));
        sa = 3'b100; sb = 3'b111;
        repeat (5) step("R11 bad B code");
        check("R11 still parked B", 32'(ps), 32'(3'b100));
        sb = 3'b110;
        repeat (40) step("R11 valid");
        sa = 3'b000; ta = 5;
        repeat (60) step("R11 rejected while running");
    endtask

    task automatic test_vld_low();
        int pulses;
        do_reset();
        ta = 2; tb = 2; tf = 1; sa = 3'b001; sb = 3'b101; nh = 2; load_vld = 1;
        repeat (30) step("R12 warmup");
        load_vld = 0; ta = 7; tb = 1; tf = 3;
        pulses = 0;
        for (int i = 0; i < 80; i++) begin
            step("R12 reuse");
            if (req) pulses++;
        end
        check("R12 req kept pulsing", 32'(pulses > 0), 32'd1);
    endtask

    initial begin
        test_reset();
        test_basic();
        test_hold();
        test_nchange();
        test_zero();
        test_invalid();
        test_vld_low();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(20 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule